// File: doc/BRIEF.md
# Snoop Write-Back Cycle Handler

This block sits in the memory bus controller. It services the write-back cycle that a cache raises when a snoop hits a modified line. The cache opens this cycle with its own snoop-address strobe. That strobe is separate from the strobe that opens ordinary cycles. The handler captures the line address and aligns it to the line boundary. It then writes the line to a simple memory write port as a fixed number of data beats. Each beat that memory accepts is acknowledged to the cache with a ready pulse, so the ready pulse is the only response the cache sees.

The write-back runs under a restricted protocol. Once started it cannot be aborted or backed off. It cannot be overlapped by a pipelined next cycle, and a second snoop strobe cannot interrupt it. The handler therefore gates the abort and next-address requests from the rest of the controller while it is busy.

An ordinary cycle start that arrives during the write-back is held, not dropped. It is released in the closing cycle of the write-back. When the handler is idle, ordinary starts, next-address requests and abort requests pass straight through in the same cycle.

Top module: `snoop_wb_handler`

## Requirements
- R1: After reset the block is idle: `wb_busy`, `mem_we`, `cache_rdy` and `cyc_go` are all 0.
- R2: When the block is idle and `wb_strobe` is sampled high at a clock edge, the block is busy from the next cycle with `mem_we` high. The address of the first beat is `wb_addr` with its low log2(BEATS*DATA_W/8) bits cleared, which is 5 bits with the default parameters.
- R3: While a write-back is active, `cache_rdy` is high exactly in the cycles in which `mem_ack` is high. Beat k (counting from 0) is issued at the line base plus k*DATA_W/8, which is k*8 by default.
- R4: The write-back ends after exactly BEATS acknowledged beats, 4 by default, however many wait cycles with `mem_ack` low come between them. One closing cycle follows, with `wb_busy` high and `mem_we` low, and then the block is idle.
- R5: While `wb_busy` is high, `abort_req` has no effect. `backoff` stays 0 and the number of beats is unchanged.
- R6: While `wb_busy` is high, `nxt_req` is not passed on. `nxt_grant` stays 0.
- R7: A `cyc_start` seen while `wb_busy` is high is held, and `cyc_go` stays 0 during the active beats. `cyc_go` pulses for one cycle in the closing cycle and is 0 afterwards.
- R8: If `wb_strobe` and `cyc_start` are both high at an idle edge, the write-back starts. The ordinary start is held as in R7, and `cyc_go` is 0 in that cycle.
- R9: A `wb_strobe` seen while `wb_busy` is high is ignored. The line base, the beat addresses and the beat count of the running write-back are unchanged.
- R10: While idle, `cyc_go` follows `cyc_start`, `nxt_grant` follows `nxt_req` and `backoff` follows `abort_req` in the same cycle. This holds whenever `wb_strobe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_strobe | input | 1 | Snoop write-back start strobe from the cache |
| wb_addr | input | ADDR_W | Address of the modified line, valid with `wb_strobe` |
| wb_wdata | input | DATA_W | Data of the current beat, supplied by the cache |
| cyc_start | input | 1 | Ordinary cycle start strobe from the cache |
| abort_req | input | 1 | Back-off request from the bus controller |
| nxt_req | input | 1 | Next-address grant request from the bus controller |
| cache_rdy | output | 1 | Ready toward the cache, one pulse per accepted beat |
| nxt_grant | output | 1 | Next-address indication toward the cache |
| backoff | output | 1 | Back-off toward the cache |
| cyc_go | output | 1 | Start of an ordinary cycle, passed on or released |
| wb_busy | output | 1 | A snoop write-back is in progress |
| mem_we | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory accepted the current write beat |

## Verification
A write-back is first run with memory acknowledging every cycle and a misaligned start address. This shows the line alignment and the beat address stepping. A second run inserts wait cycles of different lengths, which separates ready pulses tied to `mem_ack` from ready pulses tied to the cycle count. Other runs hold abort, next-address, ordinary-start and second snoop strobes high during the beats. These show that the restricted protocol neither shortens nor overlaps the cycle and that the held start comes out only in the closing cycle. Pass-through runs while idle separate gating by state from blocking that is always on.

// File: rtl/swb_pkg.sv
package swb_pkg;

    localparam int SWB_ADDR_W = 32;
    localparam int SWB_DATA_W = 64;
    localparam int SWB_BEATS  = 4;

    typedef enum logic [1:0] {
        SWB_IDLE   = 2'd0,
        SWB_ACTIVE = 2'd1,
        SWB_DONE   = 2'd2
    } swb_state_e;

    // Events seen by the sequencer in one cycle
    typedef struct packed {
        logic wb_req;
        logic beat_ack;
        logic last_beat;
    } swb_evt_t;

    // Controls produced by the sequencer
    typedef struct packed {
        logic load;
        logic active;
        logic closing;
        logic busy;
    } swb_ctl_t;

    function automatic int swb_log2(input int value);
        int r;
        r = 0;
        while ((1 << r) < value) r = r + 1;
        return r;
    endfunction

endpackage

// File: rtl/swb_fsm.sv
module swb_fsm
    import swb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  swb_evt_t   evt,
    output swb_state_e state,
    output swb_ctl_t   ctl
);

    swb_state_e state_q;
    swb_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= SWB_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SWB_IDLE:   if (evt.wb_req) state_d = SWB_ACTIVE;
            SWB_ACTIVE: if (evt.beat_ack && evt.last_beat) state_d = SWB_DONE;
            SWB_DONE:   state_d = SWB_IDLE;
            default:    state_d = SWB_IDLE;
        endcase
    end

    always_comb begin
        ctl.load    = (state_q == SWB_IDLE) && evt.wb_req;
        ctl.active  = (state_q == SWB_ACTIVE);
        ctl.closing = (state_q == SWB_DONE);
        ctl.busy    = (state_q != SWB_IDLE);
    end

    assign state = state_q;

    // R4: the closing state is reached only from an acknowledged last beat
    a_r4_done_from_last: assert property (@(posedge clk) disable iff (rst)
        (state_q == SWB_DONE) |-> ($past(state_q) == SWB_ACTIVE && $past(evt.beat_ack) && $past(evt.last_beat)));

    // R4: the closing state lasts exactly one cycle
    a_r4_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (state_q == SWB_DONE) |=> (state_q == SWB_IDLE));

    // R9: a snoop strobe while active never restarts the sequence
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (state_q == SWB_ACTIVE && !evt.beat_ack) |=> (state_q == SWB_ACTIVE));

endmodule

// File: rtl/swb_beat_ctr.sv
module swb_beat_ctr #(
    parameter int BEATS = swb_pkg::SWB_BEATS,
    localparam int CW   = (BEATS > 1) ? swb_pkg::swb_log2(BEATS) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          adv,
    output logic [CW-1:0] beat,
    output logic          last
);

    logic [CW-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (rst || load)  beat_q <= '0;
        else if (adv)     beat_q <= beat_q + CW'(1);
    end

    assign beat = beat_q;
    assign last = (beat_q == CW'(BEATS - 1));

    // R4: the counter never passes the last beat of a line
    a_r4_beat_bound: assert property (@(posedge clk) disable iff (rst)
        (32'(beat_q) < BEATS));

    // R4: a wait cycle leaves the beat index unchanged
    a_r4_hold_on_wait: assert property (@(posedge clk) disable iff (rst)
        (!adv && !load) |=> $stable(beat_q));

endmodule

// File: rtl/swb_addr_gen.sv
module swb_addr_gen #(
    parameter int ADDR_W = swb_pkg::SWB_ADDR_W,
    parameter int DATA_W = swb_pkg::SWB_DATA_W,
    parameter int BEATS  = swb_pkg::SWB_BEATS,
    localparam int CW    = (BEATS > 1) ? swb_pkg::swb_log2(BEATS) : 1,
    localparam int BYTE_SH = swb_pkg::swb_log2(DATA_W / 8),
    localparam int OFS_W   = swb_pkg::swb_log2(BEATS * (DATA_W / 8))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] line_addr,
    input  logic [CW-1:0]     beat,
    output logic [ADDR_W-1:0] beat_addr
);

    logic [ADDR_W-1:0] base_q;
    logic [ADDR_W-1:0] aligned;

    generate
        if (OFS_W > 0) begin : g_align
            assign aligned = {line_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        end else begin : g_noalign
            assign aligned = line_addr;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       base_q <= '0;
        else if (load) base_q <= aligned;
    end

    assign beat_addr = base_q | (ADDR_W'(beat) << BYTE_SH);

    // R9: the line base only changes on a load
    a_r9_base_stable: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(base_q));

endmodule

// File: rtl/swb_side_gate.sv
module swb_side_gate
    import swb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  swb_state_e state,
    input  logic       wb_strobe,
    input  logic       cyc_start,
    input  logic       abort_req,
    input  logic       nxt_req,
    output logic       cyc_go,
    output logic       nxt_grant,
    output logic       backoff
);

    logic held_q;
    logic held_d;

    always_comb begin
        held_d    = held_q;
        cyc_go    = 1'b0;
        nxt_grant = 1'b0;
        backoff   = 1'b0;
        unique case (state)
            SWB_IDLE: begin
                nxt_grant = nxt_req;
                backoff   = abort_req;
                if (wb_strobe) held_d = held_q | cyc_start;
                else           cyc_go = cyc_start;
            end
            SWB_ACTIVE: held_d = held_q | cyc_start;
            SWB_DONE: begin
                cyc_go = held_q | cyc_start;
                held_d = 1'b0;
            end
            default: held_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) held_q <= 1'b0;
        else     held_q <= held_d;
    end

    // R7: no ordinary cycle starts during active beats
    a_r7_quiet_active: assert property (@(posedge clk) disable iff (rst)
        (state == SWB_ACTIVE) |-> !cyc_go);

    // R8: a start that coincides with a snoop strobe is held for later
    a_r8_held_on_tie: assert property (@(posedge clk) disable iff (rst)
        (state == SWB_IDLE && wb_strobe && cyc_start) |=> held_q);

    // R5 / R6: the restricted protocol blocks abort and pipelining
    a_r5_no_backoff_busy: assert property (@(posedge clk) disable iff (rst)
        (state != SWB_IDLE) |-> !backoff);
    a_r6_no_grant_busy: assert property (@(posedge clk) disable iff (rst)
        (state != SWB_IDLE) |-> !nxt_grant);

endmodule

// File: rtl/snoop_wb_handler.sv
module snoop_wb_handler
    import swb_pkg::*;
#(
    parameter int ADDR_W = SWB_ADDR_W,
    parameter int DATA_W = SWB_DATA_W,
    parameter int BEATS  = SWB_BEATS,
    localparam int CW    = (BEATS > 1) ? swb_log2(BEATS) : 1,
    localparam int OFS_W = swb_log2(BEATS * (DATA_W / 8))
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_strobe,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [DATA_W-1:0] wb_wdata,
    input  logic              cyc_start,
    input  logic              abort_req,
    input  logic              nxt_req,
    output logic              cache_rdy,
    output logic              nxt_grant,
    output logic              backoff,
    output logic              cyc_go,
    output logic              wb_busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack
);

    swb_evt_t      evt;
    swb_ctl_t      ctl;
    swb_state_e    state;
    logic [CW-1:0] beat;
    logic          last;
    logic          beat_acc;

    assign beat_acc = ctl.active && mem_ack;

    always_comb begin
        evt.wb_req    = wb_strobe;
        evt.beat_ack  = beat_acc;
        evt.last_beat = last;
    end

    swb_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .evt   (evt),
        .state (state),
        .ctl   (ctl)
    );

    swb_beat_ctr #(.BEATS(BEATS)) u_beat (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.load),
        .adv  (beat_acc),
        .beat (beat),
        .last (last)
    );

    swb_addr_gen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (ctl.load),
        .line_addr (wb_addr),
        .beat      (beat),
        .beat_addr (mem_addr)
    );

    swb_side_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .state     (state),
        .wb_strobe (wb_strobe),
        .cyc_start (cyc_start),
        .abort_req (abort_req),
        .nxt_req   (nxt_req),
        .cyc_go    (cyc_go),
        .nxt_grant (nxt_grant),
        .backoff   (backoff)
    );

    assign mem_we    = ctl.active;
    assign mem_wdata = wb_wdata;
    assign cache_rdy = beat_acc;
    assign wb_busy   = ctl.busy;

    // R3: ready toward the cache only for a write that memory accepted
    a_r3_rdy_needs_ack: assert property (@(posedge clk) disable iff (rst)
        cache_rdy |-> (mem_ack && mem_we));

    // R2: the first beat sits on a line boundary
    a_r2_first_aligned: assert property (@(posedge clk) disable iff (rst)
        (mem_we && beat == '0) |-> (mem_addr[OFS_W-1:0] == '0));

    // R4: write requests stop once the closing cycle is reached
    a_r4_no_write_closing: assert property (@(posedge clk) disable iff (rst)
        (wb_busy && !mem_we) |=> !wb_busy);

    // R1: reset leaves the block idle
    a_r1_idle_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (!wb_busy && !mem_we));

endmodule

// File: tb/snoop_wb_handler_bench.sv
module snoop_wb_handler_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int NB = 4;
    localparam int STEP = DW / 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          wb_strobe, cyc_start, abort_req, nxt_req, mem_ack;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_wdata;
    logic          cache_rdy, nxt_grant, backoff, cyc_go, wb_busy, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    snoop_wb_handler u_snoop_wb_handler (
        .clk(clk), .rst(rst), .wb_strobe(wb_strobe), .wb_addr(wb_addr),
        .wb_wdata(wb_wdata), .cyc_start(cyc_start), .abort_req(abort_req),
        .nxt_req(nxt_req), .cache_rdy(cache_rdy), .nxt_grant(nxt_grant),
        .backoff(backoff), .cyc_go(cyc_go), .wb_busy(wb_busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic quiet_inputs();
        wb_strobe = 0; cyc_start = 0; abort_req = 0; nxt_req = 0; mem_ack = 0;
        wb_addr = '0; wb_wdata = '0;
    endtask

    // Open a write-back; returns in the first active cycle
    task automatic open_wb(input logic [AW-1:0] a, input logic with_cyc);
        @(negedge clk);
        wb_strobe = 1; wb_addr = a; cyc_start = with_cyc;
        #1;
        if (with_cyc) check("R8", "cyc_go on tie", cyc_go, 0);
        @(negedge clk);
        wb_strobe = 0; cyc_start = 0;
    endtask

    // One beat, with wait cycles before the acknowledge
    task automatic do_beat(input string req, input int k, input logic [AW-1:0] base, input int waits);
        for (int w = 0; w < waits; w++) begin
            mem_ack = 0; #1;
            check(req, "rdy during wait", cache_rdy, 0);
            check(req, "mem_we during wait", mem_we, 1);
            @(negedge clk);
        end
        mem_ack = 1; wb_wdata = DW'(64'hA5A5_0000_0000_0000 + k); #1;
        check(req, "rdy on ack", cache_rdy, 1);
        check(req, "beat addr", mem_addr, base + AW'(k * STEP));
        check(req, "beat data", mem_wdata, DW'(64'hA5A5_0000_0000_0000 + k));
        @(negedge clk);
        mem_ack = 0;
    endtask

    task automatic t_reset();
        rst = 1; quiet_inputs();
        repeat (3) @(negedge clk);
        rst = 0; #1;
        check("R1", "busy", wb_busy, 0);
        check("R1", "mem_we", mem_we, 0);
        check("R1", "rdy", cache_rdy, 0);
        check("R1", "cyc_go", cyc_go, 0);
    endtask

    task automatic t_idle_pass();
        @(negedge clk);
        cyc_start = 1; nxt_req = 1; abort_req = 1; #1;
        check("R10", "cyc_go", cyc_go, 1);
        check("R10", "nxt_grant", nxt_grant, 1);
        check("R10", "backoff", backoff, 1);
        check("R10", "busy", wb_busy, 0);
        @(negedge clk);
        quiet_inputs(); #1;
        check("R10", "cyc_go low", cyc_go, 0);
    endtask

    task automatic t_basic();
        logic [AW-1:0] base = 32'h1234_5660;
        open_wb(32'h1234_5678, 0); #1;
        check("R2", "busy", wb_busy, 1);
        check("R2", "mem_we", mem_we, 1);
        check("R2", "aligned addr", mem_addr, base);
        for (int k = 0; k < NB; k++) do_beat("R3", k, base, 0);
        #1;
        check("R4", "closing busy", wb_busy, 1);
        check("R4", "closing mem_we", mem_we, 0);
        check("R4", "closing rdy", cache_rdy, 0);
        @(negedge clk); #1;
        check("R4", "idle after", wb_busy, 0);
    endtask

    task automatic t_waits();
        logic [AW-1:0] base = 32'h0000_8020;
        open_wb(32'h0000_803F, 0);
        do_beat("R4", 0, base, 2);
        do_beat("R4", 1, base, 0);
        do_beat("R4", 2, base, 3);
        do_beat("R4", 3, base, 1);
        #1;
        check("R4", "closing after 4 beats", {wb_busy, mem_we}, 2'b10);
        @(negedge clk); #1;
        check("R4", "idle after waits", wb_busy, 0);
    endtask

    task automatic t_inject();
        logic [AW-1:0] base = 32'h00F0_0000;
        open_wb(32'h00F0_0008, 0);
        abort_req = 1; nxt_req = 1;
        for (int k = 0; k < NB; k++) begin
            #1;
            check("R5", "backoff busy", backoff, 0);
            check("R6", "nxt_grant busy", nxt_grant, 0);
            check("R5", "still writing", mem_we, 1);
            do_beat("R5", k, base, 1);
        end
        #1;
        check("R6", "grant in closing", nxt_grant, 0);
        check("R5", "backoff in closing", backoff, 0);
        @(negedge clk); #1;
        check("R10", "backoff back", backoff, 1);
        check("R10", "grant back", nxt_grant, 1);
        abort_req = 0; nxt_req = 0;
    endtask

    task automatic t_queued();
        logic [AW-1:0] base = 32'h0000_0100;
        open_wb(32'h0000_0100, 0);
        do_beat("R7", 0, base, 0);
        cyc_start = 1; #1;
        check("R7", "cyc_go held", cyc_go, 0);
        @(negedge clk);
        cyc_start = 0;
        do_beat("R7", 1, base, 0);
        do_beat("R7", 2, base, 0);
        do_beat("R7", 3, base, 0);
        #1;
        check("R7", "release in closing", cyc_go, 1);
        @(negedge clk); #1;
        check("R7", "single pulse", cyc_go, 0);
    endtask

    task automatic t_tie();
        logic [AW-1:0] base = 32'h0000_0200;
        open_wb(32'h0000_0210, 1); #1;
        check("R8", "snoop won", wb_busy, 1);
        check("R8", "cyc_go active", cyc_go, 0);
        for (int k = 0; k < NB; k++) do_beat("R8", k, base, 0);
        #1;
        check("R8", "held start released", cyc_go, 1);
        @(negedge clk);
    endtask

    task automatic t_second_strobe();
        logic [AW-1:0] base = 32'h0000_0400;
        open_wb(32'h0000_0400, 0);
        do_beat("R9", 0, base, 0);
        wb_strobe = 1; wb_addr = 32'h0000_0900;
        do_beat("R9", 1, base, 0);
        wb_strobe = 0;
        do_beat("R9", 2, base, 0);
        do_beat("R9", 3, base, 0);
        #1;
        check("R9", "closing after 4", {wb_busy, mem_we}, 2'b10);
        @(negedge clk); #1;
        check("R9", "idle", wb_busy, 0);
    endtask

    initial begin
        quiet_inputs(); rst = 1;
        t_reset();
        t_idle_pass();
        t_basic();
        t_waits();
        t_inject();
        t_queued();
        t_tie();
        t_second_strobe();
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            n_checks++; n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule